// File: doc/BRIEF.md
# Display Store Host Bus Slave

This block lets a host processor reach the internal stores of an eight-position 5x7 dot-matrix display controller. The host uses an 8-bit data bus, a 5-bit address and four active-low strobes: chip enable, read, write and flash select. Every access goes to exactly one of five targets. These are the character store, the per-position flash attribute bits, the user-glyph pointer, the user-glyph row store and the control byte.

The user-glyph row store is reached indirectly. The host first loads a 4-bit glyph pointer, and later row accesses land in the glyph that the pointer names. The flash-select strobe takes priority over the section bits of the address. The strobes are sampled on the system clock. Read data comes back one clock after the strobes are seen, together with an output-enable that steers the tristate buffer at the chip edge.

While the controller runs an internal clear, reset or self-test sequence, it raises `seq_busy`. During that time the block accepts no writes and returns zeros on reads.

Top module: `glyph_bus_slave`

## Requirements
- R1: A write is committed only on a clock edge where `ce_n` and `we_n` are both sampled low and `seq_busy` is low. Only one write is committed per low period of `ce_n`: after the first write edge, further write edges are ignored until `ce_n` has been sampled high.
- R2: `bus_oe` is 1 in the cycle after an edge where `ce_n` and `re_n` were both sampled low, and 0 otherwise. While `bus_oe` is 0, `bus_dout` is 0.
- R3: When `flash_n` is low, the access targets the flash bit of position `addr[2:0]`, whatever `addr[4:3]` holds. A write stores `din[0]`. A read returns that bit in bit 0, with bits 7:1 zero.
- R4: When `flash_n` is high, `addr[4:3]` picks the target: 0 is the glyph pointer, 1 is the glyph row store, 2 is the control byte, and 3 is the character store.
- R5: The character store holds one full 8-bit byte for each of the eight positions, indexed by `addr[2:0]`, and reads back all 8 bits unchanged.
- R6: The glyph pointer stores `din[3:0]`. A read returns it in bits 3:0, with bits 7:4 zero.
- R7: A glyph row access addresses row `addr[2:0]` of the glyph named by the pointer. A write stores `din[4:0]`, where bit 4 is the leftmost dot. A read returns those bits with bits 7:5 zero. Row index 7 is not a row: writes to it change nothing and reads of it return 0.
- R8: While `seq_busy` is 1, no store changes, and a read returns 0 with `bus_oe` still asserted.
- R9: After reset, the control byte, the glyph pointer and all flash bits read 0, and `bus_oe` is 0.
- R10: The control byte stores and reads back all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| ce_n | input | 1 | chip enable, active low |
| re_n | input | 1 | read strobe, active low |
| we_n | input | 1 | write strobe, active low |
| flash_n | input | 1 | flash-bit select, active low, takes priority over the section bits |
| addr | input | 5 | bits 4:3 select the section, bits 2:0 select the position or row |
| din | input | 8 | write data from the host |
| seq_busy | input | 1 | internal clear, reset or self-test sequence is running |
| bus_dout | output | 8 | registered read data |
| bus_oe | output | 1 | registered output enable for the data bus buffer |

## Verification
The hardest case to reach is a glyph row access that depends on a pointer written several transactions earlier. The stimulus writes every row of all sixteen glyphs through a fresh pointer load for each glyph. It then mixes random pointer reloads with random row reads and writes, so that a wrong index shows up in a glyph other than the one written.

Directed sequences cover the remaining cases:
- a write strobe pulsed twice while chip enable stays low;
- row index 7;
- flash accesses with each value of the section bits;
- accesses made while the busy flag is up.

// File: rtl/glyph_bus_pkg.sv
package glyph_bus_pkg;
  typedef enum logic [2:0] {
    TGT_PTR   = 3'd0,
    TGT_ROW   = 3'd1,
    TGT_CTRL  = 3'd2,
    TGT_CHAR  = 3'd3,
    TGT_FLASH = 3'd4
  } tgt_e;
endpackage

// File: rtl/glyph_bus_decode.sv
module glyph_bus_decode
  import glyph_bus_pkg::*;
(
  input  logic       flash_n,
  input  logic [1:0] sect,
  output tgt_e       tgt
);
  always_comb begin
    if (!flash_n) tgt = TGT_FLASH;
    else begin
      unique case (sect)
        2'd0:    tgt = TGT_PTR;
        2'd1:    tgt = TGT_ROW;
        2'd2:    tgt = TGT_CTRL;
        default: tgt = TGT_CHAR;
      endcase
    end
  end
endmodule

// File: rtl/glyph_bus_strobe.sv
module glyph_bus_strobe (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic re_n,
  input  logic we_n,
  input  logic seq_busy,
  output logic wr_fire,
  output logic rd_req
);
  logic taken_q;

  always_ff @(posedge clk) begin
    if (rst)                taken_q <= 1'b0;
    else if (ce_n)          taken_q <= 1'b0;
    else if (!we_n)         taken_q <= 1'b1;
  end

  assign wr_fire = !ce_n && !we_n && !taken_q && !seq_busy;
  assign rd_req  = !ce_n && !re_n;

  assert_one_write_R1: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> !wr_fire);
endmodule

// File: rtl/glyph_bus_store.sv
module glyph_bus_store
  import glyph_bus_pkg::*;
#(
  parameter int N_POS  = 8,
  parameter int N_GLY  = 16,
  parameter int N_ROWS = 7,
  parameter int ROW_W  = 5,
  parameter int DW     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  tgt_e                       tgt,
  input  logic [$clog2(N_POS)-1:0]   idx,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata
);
  localparam int PW    = $clog2(N_POS);
  localparam int GW    = $clog2(N_GLY);
  localparam int DEPTH = N_GLY * (2 ** PW);

  logic [DW-1:0]    char_mem [N_POS];
  logic [ROW_W-1:0] row_mem  [DEPTH];
  logic [N_POS-1:0] flash_q;
  logic [GW-1:0]    ptr_q;
  logic [DW-1:0]    ctrl_q;
  logic             row_ok;

  assign row_ok = (int'(idx) < N_ROWS);

  always_ff @(posedge clk)
    if (wr_en && tgt == TGT_CHAR) char_mem[idx] <= wdata;

  always_ff @(posedge clk)
    if (wr_en && tgt == TGT_ROW && row_ok) row_mem[{ptr_q, idx}] <= wdata[ROW_W-1:0];

  for (genvar p = 0; p < N_POS; p++) begin : g_flash
    always_ff @(posedge clk) begin
      if (rst) flash_q[p] <= 1'b0;
      else if (wr_en && tgt == TGT_FLASH && int'(idx) == p) flash_q[p] <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (tgt == TGT_PTR)  ptr_q  <= wdata[GW-1:0];
      if (tgt == TGT_CTRL) ctrl_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (tgt)
      TGT_PTR:   rdata[GW-1:0] = ptr_q;
      TGT_ROW:   if (row_ok) rdata[ROW_W-1:0] = row_mem[{ptr_q, idx}];
      TGT_CTRL:  rdata = ctrl_q;
      TGT_CHAR:  rdata = char_mem[idx];
      TGT_FLASH: rdata[0] = flash_q[idx];
      default:   rdata = '0;
    endcase
  end

  assert_row_pad_R7: assert property (@(posedge clk) disable iff (rst)
    (tgt == TGT_ROW) |-> (rdata[DW-1:ROW_W] == '0) && (row_ok || rdata == '0));
  assert_flash_pad_R3: assert property (@(posedge clk) disable iff (rst)
    (tgt == TGT_FLASH) |-> (rdata[DW-1:1] == '0));
endmodule

// File: rtl/glyph_bus_slave.sv
module glyph_bus_slave
  import glyph_bus_pkg::*;
#(
  parameter int N_POS  = 8,
  parameter int N_GLY  = 16,
  parameter int N_ROWS = 7,
  parameter int ROW_W  = 5,
  parameter int DW     = 8,
  parameter int AW     = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          re_n,
  input  logic          we_n,
  input  logic          flash_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          seq_busy,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe
);
  localparam int PW = $clog2(N_POS);

  tgt_e          tgt;
  logic          wr_fire;
  logic          rd_req;
  logic [DW-1:0] rdata;

  glyph_bus_decode u_dec (
    .flash_n (flash_n),
    .sect    (addr[AW-1:AW-2]),
    .tgt     (tgt)
  );

  glyph_bus_strobe u_stb (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .re_n     (re_n),
    .we_n     (we_n),
    .seq_busy (seq_busy),
    .wr_fire  (wr_fire),
    .rd_req   (rd_req)
  );

  glyph_bus_store #(
    .N_POS (N_POS), .N_GLY (N_GLY), .N_ROWS (N_ROWS), .ROW_W (ROW_W), .DW (DW)
  ) u_mem (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_fire),
    .tgt   (tgt),
    .idx   (addr[PW-1:0]),
    .wdata (din),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe   <= 1'b0;
      bus_dout <= '0;
    end else begin
      bus_oe   <= rd_req;
      bus_dout <= (rd_req && !seq_busy) ? rdata : '0;
    end
  end

  assert_oe_on_read_R2: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !re_n) |=> bus_oe);
  assert_oe_off_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !(!ce_n && !re_n) |=> !bus_oe);
  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_dout == '0));
  assert_busy_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && !ce_n && !re_n) |=> (bus_dout == '0));
endmodule

// File: tb/glyph_bus_slave_tb.sv
module glyph_bus_slave_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce_n = 1'b1, re_n = 1'b1, we_n = 1'b1, flash_n = 1'b1, seq_busy = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] bus_dout;
  logic       bus_oe;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] char_m [8];
  logic       flash_m [8];
  logic [3:0] ptr_m;
  logic [4:0] row_m [128];
  logic [7:0] ctrl_m;

  glyph_bus_slave u_dut (
    .clk (clk), .rst (rst), .ce_n (ce_n), .re_n (re_n), .we_n (we_n),
    .flash_n (flash_n), .addr (addr), .din (din), .seq_busy (seq_busy),
    .bus_dout (bus_dout), .bus_oe (bus_oe)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic fl, input logic [4:0] a, input logic [7:0] d);
    if (!fl) flash_m[a[2:0]] = d[0];
    else case (a[4:3])
      2'd0: ptr_m = d[3:0];
      2'd1: if (a[2:0] != 3'd7) row_m[{ptr_m, a[2:0]}] = d[4:0];
      2'd2: ctrl_m = d;
      default: char_m[a[2:0]] = d;
    endcase
  endtask

  function automatic logic [7:0] model_rd(input logic fl, input logic [4:0] a);
    if (!fl) return {7'd0, flash_m[a[2:0]]};
    case (a[4:3])
      2'd0: return {4'd0, ptr_m};
      2'd1: return (a[2:0] == 3'd7) ? 8'd0 : {3'd0, row_m[{ptr_m, a[2:0]}]};
      2'd2: return ctrl_m;
      default: return char_m[a[2:0]];
    endcase
  endfunction

  function automatic string tag_of(input logic fl, input logic [4:0] a);
    if (!fl) return "R3 flash";
    case (a[4:3])
      2'd0: return "R6 pointer";
      2'd1: return "R7 row";
      2'd2: return "R10 control";
      default: return "R5 char";
    endcase
  endfunction

  task automatic bus_wr(input logic fl, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; flash_n = fl; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; flash_n = 1'b1;
    if (!seq_busy) model_wr(fl, a, d);
  endtask

  task automatic bus_rd(input logic fl, input logic [4:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    ce_n = 1'b0; re_n = 1'b0; flash_n = fl; addr = a;
    @(negedge clk);
    d = bus_dout; oe = bus_oe;
    ce_n = 1'b1; re_n = 1'b1; flash_n = 1'b1;
  endtask

  task automatic rd_chk(input logic fl, input logic [4:0] a);
    logic [7:0] d;
    logic oe;
    bus_rd(fl, a, d, oe);
    chk(tag_of(fl, a), d, model_rd(fl, a));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic oe;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin char_m[i] = '0; flash_m[i] = 1'b0; end
    for (int i = 0; i < 128; i++) row_m[i] = '0;
    ptr_m = '0; ctrl_m = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    @(negedge clk);
    chk("R9 oe after reset", {7'd0, bus_oe}, 8'd0);
    bus_rd(1'b1, 5'b10_000, d, oe); chk("R9 control", d, 8'd0);
    bus_rd(1'b1, 5'b00_000, d, oe); chk("R9 pointer", d, 8'd0);
    bus_rd(1'b0, 5'b00_101, d, oe); chk("R9 flash", d, 8'd0);

    // R2 oe timing: asserted for read, dropped right after
    chk("R2 oe during read", {7'd0, oe}, 8'd1);
    @(negedge clk);
    chk("R2 oe after read", {7'd0, bus_oe}, 8'd0);
    chk("R2 dout quiet", bus_dout, 8'd0);

    // fill stores
    for (int p = 0; p < 8; p++) bus_wr(1'b1, {2'b11, 3'(p)}, 8'($urandom));
    for (int g = 0; g < 16; g++) begin
      bus_wr(1'b1, 5'b00_000, 8'(g) | 8'hA0);
      for (int r = 0; r < 7; r++) bus_wr(1'b1, {2'b01, 3'(r)}, 8'($urandom));
    end
    for (int p = 0; p < 8; p++) rd_chk(1'b1, {2'b11, 3'(p)});
    rd_chk(1'b1, 5'b00_000);

    // R7 row 7 ignored, pad bits
    bus_wr(1'b1, 5'b01_111, 8'hFF);
    rd_chk(1'b1, 5'b01_111);
    bus_wr(1'b1, 5'b01_010, 8'hF5);
    bus_rd(1'b1, 5'b01_010, d, oe); chk("R7 upper bits dropped", d, 8'h15);

    // R3 flash with each section value
    for (int s = 0; s < 4; s++) begin
      bus_wr(1'b0, {2'(s), 3'(s + 2)}, 8'hFF);
      bus_rd(1'b0, {2'(3 - s), 3'(s + 2)}, d, oe); chk("R3 flash ignores section", d, 8'h01);
    end
    bus_wr(1'b0, 5'b11_010, 8'hFE);
    rd_chk(1'b0, 5'b00_010);
    rd_chk(1'b1, 5'b11_010);

    // R10 control full byte
    bus_wr(1'b1, 5'b10_011, 8'hC3);
    bus_rd(1'b1, 5'b10_000, d, oe); chk("R10 control", d, 8'hC3);

    // R1 one write per enable period
    @(negedge clk); ce_n = 0; we_n = 0; flash_n = 1; addr = 5'b11_100; din = 8'h3C;
    @(negedge clk); din = 8'h99;
    @(negedge clk); we_n = 1;
    @(negedge clk); we_n = 0; din = 8'h77;
    @(negedge clk); ce_n = 1; we_n = 1;
    char_m[4] = 8'h3C;
    bus_rd(1'b1, 5'b11_100, d, oe); chk("R1 single write per enable", d, 8'h3C);
    // R1 write strobe without chip enable
    @(negedge clk); ce_n = 1; we_n = 0; addr = 5'b11_100; din = 8'h11;
    @(negedge clk); we_n = 1;
    bus_rd(1'b1, 5'b11_100, d, oe); chk("R1 no write without enable", d, 8'h3C);

    // R8 busy blocks
    seq_busy = 1'b1;
    bus_wr(1'b1, 5'b10_000, 8'h5A);
    bus_rd(1'b1, 5'b10_000, d, oe);
    chk("R8 busy read zero", d, 8'h00);
    chk("R8 busy oe still on", {7'd0, oe}, 8'd1);
    seq_busy = 1'b0;
    bus_rd(1'b1, 5'b10_000, d, oe); chk("R8 busy write blocked", d, 8'hC3);

    // random mix, R4 decode across all targets
    for (int i = 0; i < 400; i++) begin
      logic fl;
      logic [4:0] a;
      fl = ($urandom_range(3) != 0);
      a  = 5'($urandom);
      if ($urandom_range(1) == 1) bus_wr(fl, a, 8'($urandom));
      else rd_chk(fl, a);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule